// File: doc/BRIEF.md
# Double-Buffered Wide Write Register

This block holds a control register that is wider than the CPU data path. Software fills it one sub-word per bus write. Each write lands in a hidden staging buffer. The visible register, which drives the hardware, takes the whole staged value in one clock edge when a commit event occurs, so the hardware never sees a mix of old and new sub-words. Because of this, a field may straddle a sub-word boundary and still change atomically.

A build-time parameter chooses the commit source. In self mode, any accepted write to the highest sub-word commits. In external mode, a one-bit strobe commits. That strobe can come from a pulse or status bit elsewhere in the chip. A write in the same cycle as a commit is merged into the staged value first, so it becomes visible with that commit. A read of the register returns the committed value, taken directly from the output.

Top module: `dbw_reg`

## Requirements
- R1: On a clock edge with `rst_n` low, both the committed value `reg_q` and the staging buffer take `RESET_VAL`, and `updated` goes low.
- R2: An accepted write changes only sub-word `wr_idx` of the staging buffer. That sub-word covers register bits `[wr_idx*SUB_W +: SUB_W]`. Within it, only the bytes whose `wr_strb` bit is 1 change, and strobe bit b selects byte b of the sub-word.
- R3: A write is accepted only when `wr_hit` and `wr_en` are both 1 and `wr_idx < REG_W/SUB_W`. Any other write leaves both the staging buffer and `reg_q` unchanged.
- R4: In self mode (`TRIG_MODE = TRIG_SELF`), an accepted write with `wr_idx = REG_W/SUB_W-1` commits. This holds even when all strobes are 0. `reg_q` shows the staged value one cycle later.
- R5: In external mode (`TRIG_MODE = TRIG_EXT`), `ext_trig` = 1 commits and no write commits. In self mode, `ext_trig` has no effect.
- R6: When an accepted write and a commit fall in the same cycle, the committed value includes that write's bytes.
- R7: `updated` is 1 in exactly the cycle after each commit and 0 at all other times.
- R8: `reg_q` changes only on a commit or a reset. Sub-word writes between commits, including writes to a field that straddles sub-words, leave `reg_q` holding its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_hit | input | 1 | Address decode selects this register |
| wr_en | input | 1 | Write cycle on the register bus |
| wr_idx | input | IDX_W | Sub-word index (bit position / SUB_W) |
| wr_data | input | SUB_W | Write data for one sub-word |
| wr_strb | input | SUB_W/8 | Byte strobes within the sub-word |
| ext_trig | input | 1 | One-bit commit strobe (external mode) |
| reg_q | output | REG_W | Committed register value driving hardware |
| updated | output | 1 | One-cycle pulse after each commit |

## Verification
The bench builds two copies with a 48-bit register and 16-bit sub-words. One copy uses self mode and the other uses external mode, and both are driven by the same bus. With three sub-words, the 2-bit index can take the value 3, so the out-of-range case can be reached. The upper-sub-word commit is also distinct from the lower writes. With two strobes per sub-word, every byte-mask pattern can be swept at every index, with and without a simultaneous trigger. A pseudo-random phase then varies `wr_hit` and `wr_en` and resets the block mid-run. This confirms that staged bytes are discarded by the reset.

// File: rtl/dbw_pkg.sv
package dbw_pkg;
   typedef enum logic {
      TRIG_SELF = 1'b0,
      TRIG_EXT  = 1'b1
   } trig_mode_e;

   function automatic int unsigned idx_width(input int unsigned nsub);
      return (nsub > 1) ? $clog2(nsub) : 1;
   endfunction
endpackage

// File: rtl/dbw_stage.sv
module dbw_stage #(
   parameter int unsigned REG_W              = 64,
   parameter int unsigned SUB_W              = 32,
   parameter logic [REG_W-1:0] RESET_VAL     = '0,
   localparam int unsigned NSUB              = REG_W / SUB_W,
   localparam int unsigned NBYTE             = SUB_W / 8,
   localparam int unsigned IDX_W             = dbw_pkg::idx_width(NSUB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SUB_W-1:0]  wr_data,
   input  logic [NBYTE-1:0]  wr_strb,
   output logic [REG_W-1:0]  stage_nxt
);
   logic [REG_W-1:0] stage_q;

   for (genvar s = 0; s < NSUB; s++) begin : g_sub
      logic sel;
      assign sel = wr_ok && (wr_idx == IDX_W'(s));
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
         assign stage_nxt[s*SUB_W + b*8 +: 8] =
            (sel && wr_strb[b]) ? wr_data[b*8 +: 8] : stage_q[s*SUB_W + b*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stage_q <= RESET_VAL;
      else        stage_q <= stage_nxt;
   end
endmodule

// File: rtl/dbw_trig.sv
module dbw_trig #(
   parameter int unsigned NSUB               = 2,
   parameter dbw_pkg::trig_mode_e TRIG_MODE  = dbw_pkg::TRIG_SELF,
   localparam int unsigned IDX_W             = dbw_pkg::idx_width(NSUB),
   localparam logic [IDX_W-1:0] LAST_IDX     = IDX_W'(NSUB - 1)
) (
   input  logic             wr_ok,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             ext_trig,
   output logic             commit
);
   logic self_hit;
   assign self_hit = wr_ok && (wr_idx == LAST_IDX);

   if (TRIG_MODE == dbw_pkg::TRIG_SELF) begin : g_self
      assign commit = self_hit | (ext_trig & 1'b0);
   end else begin : g_ext
      assign commit = ext_trig | (self_hit & 1'b0);
   end
endmodule

// File: rtl/dbw_commit.sv
module dbw_commit #(
   parameter int unsigned REG_W          = 64,
   parameter logic [REG_W-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [REG_W-1:0] stage_nxt,
   output logic [REG_W-1:0] reg_q,
   output logic             updated
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_q   <= RESET_VAL;
         updated <= 1'b0;
      end else begin
         updated <= commit;
         if (commit) reg_q <= stage_nxt;
      end
   end
endmodule

// File: rtl/dbw_reg.sv
module dbw_reg #(
   parameter int unsigned REG_W              = 64,
   parameter int unsigned SUB_W              = 32,
   parameter logic [REG_W-1:0] RESET_VAL     = '0,
   parameter dbw_pkg::trig_mode_e TRIG_MODE  = dbw_pkg::TRIG_SELF,
   localparam int unsigned NSUB              = REG_W / SUB_W,
   localparam int unsigned NBYTE             = SUB_W / 8,
   localparam int unsigned IDX_W             = dbw_pkg::idx_width(NSUB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [SUB_W-1:0]  wr_data,
   input  logic [NBYTE-1:0]  wr_strb,
   input  logic              ext_trig,
   output logic [REG_W-1:0]  reg_q,
   output logic              updated
);
   if (SUB_W == 0 || (SUB_W % 8) != 0) begin : g_bad_sub
      $error("dbw_reg: SUB_W must be a non-zero multiple of 8");
   end
   if (REG_W <= SUB_W || (REG_W % SUB_W) != 0) begin : g_bad_reg
      $error("dbw_reg: REG_W must be a multiple of SUB_W and wider than it");
   end

   logic             wr_ok;
   logic             commit;
   logic [REG_W-1:0] stage_nxt;

   assign wr_ok = wr_hit && wr_en && (32'(wr_idx) < NSUB);

   dbw_stage #(.REG_W(REG_W), .SUB_W(SUB_W), .RESET_VAL(RESET_VAL)) stage_i (
      .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_strb(wr_strb), .stage_nxt(stage_nxt)
   );

   dbw_trig #(.NSUB(NSUB), .TRIG_MODE(TRIG_MODE)) trig_i (
      .wr_ok(wr_ok), .wr_idx(wr_idx), .ext_trig(ext_trig), .commit(commit)
   );

   dbw_commit #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) commit_i (
      .clk(clk), .rst_n(rst_n), .commit(commit), .stage_nxt(stage_nxt),
      .reg_q(reg_q), .updated(updated)
   );
endmodule

// File: rtl/dbw_reg_chk.sv
module dbw_reg_chk #(
   parameter int unsigned REG_W              = 64,
   parameter int unsigned SUB_W              = 32,
   parameter logic [REG_W-1:0] RESET_VAL     = '0,
   parameter dbw_pkg::trig_mode_e TRIG_MODE  = dbw_pkg::TRIG_SELF,
   localparam int unsigned NSUB              = REG_W / SUB_W,
   localparam int unsigned NBYTE             = SUB_W / 8,
   localparam int unsigned IDX_W             = dbw_pkg::idx_width(NSUB)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_hit,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [SUB_W-1:0]  wr_data,
   input logic [NBYTE-1:0]  wr_strb,
   input logic              ext_trig,
   input logic [REG_W-1:0]  reg_q,
   input logic              updated
);
   localparam bit SELF = (TRIG_MODE == dbw_pkg::TRIG_SELF);

   logic top_wr;
   logic ev;
   assign top_wr = wr_hit && wr_en && (32'(wr_idx) == NSUB - 1);
   assign ev     = SELF ? top_wr : ext_trig;

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (reg_q == RESET_VAL) && !updated);

   assert_self_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (SELF && top_wr && (&wr_strb)) |=> reg_q[REG_W-1 -: SUB_W] == $past(wr_data));

   assert_ext_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!SELF && !ext_trig) |=> $stable(reg_q));

   assert_pulse_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> updated);

   assert_pulse_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ev |=> !updated);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !updated |-> $stable(reg_q));
endmodule

bind dbw_reg dbw_reg_chk #(
   .REG_W(REG_W), .SUB_W(SUB_W), .RESET_VAL(RESET_VAL), .TRIG_MODE(TRIG_MODE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_data(wr_data), .wr_strb(wr_strb), .ext_trig(ext_trig),
   .reg_q(reg_q), .updated(updated)
);

// File: tb/dbw_reg_tb.sv
module dbw_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RW   = 48;
   localparam int SW   = 16;
   localparam int NS   = RW / SW;
   localparam int NB   = SW / 8;
   localparam int IW   = 2;
   localparam logic [RW-1:0] RV = 48'h1234_5678_9ABC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_hit = 1'b0, wr_en = 1'b0, ext_trig = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [SW-1:0] wr_data = '0;
   logic [NB-1:0] wr_strb = '0;
   logic [RW-1:0] q_s, q_x;
   logic          upd_s, upd_x;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   logic [RW-1:0] st_s, st_x, rq_s, rq_x;
   logic          eu_s, eu_x;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbw_reg #(.REG_W(RW), .SUB_W(SW), .RESET_VAL(RV), .TRIG_MODE(dbw_pkg::TRIG_SELF)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_strb(wr_strb), .ext_trig(ext_trig),
      .reg_q(q_s), .updated(upd_s));

   dbw_reg #(.REG_W(RW), .SUB_W(SW), .RESET_VAL(RV), .TRIG_MODE(dbw_pkg::TRIG_EXT)) dut_x_i (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .wr_strb(wr_strb), .ext_trig(ext_trig),
      .reg_q(q_x), .updated(upd_x));

   task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Drive one cycle, advance the model, then check after the edge.
   task automatic op(input logic h, input logic e, input logic [IW-1:0] idx,
                     input logic [SW-1:0] d, input logic [NB-1:0] sb, input logic t,
                     input string req);
      logic v;
      wr_hit = h; wr_en = e; wr_idx = idx; wr_data = d; wr_strb = sb; ext_trig = t;
      v = h && e && (int'(idx) < NS);
      if (v) begin
         for (int b = 0; b < NB; b++) begin
            if (sb[b]) begin
               st_s[int'(idx)*SW + b*8 +: 8] = d[b*8 +: 8];
               st_x[int'(idx)*SW + b*8 +: 8] = d[b*8 +: 8];
            end
         end
      end
      eu_s = v && (int'(idx) == NS-1);
      eu_x = t;
      if (eu_s) rq_s = st_s;
      if (eu_x) rq_x = st_x;
      @(posedge clk);
      @(negedge clk);
      chk(q_s == rq_s, {req, " self reg_q"}, q_s, rq_s);
      chk(q_x == rq_x, {req, " ext reg_q"}, q_x, rq_x);
      chk(upd_s == eu_s, "R7 self updated", RW'(upd_s), RW'(eu_s));
      chk(upd_x == eu_x, "R7 ext updated", RW'(upd_x), RW'(eu_x));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_hit = 0; wr_en = 0; ext_trig = 0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      st_s = RV; st_x = RV; rq_s = RV; rq_x = RV;
      chk(q_s == RV && q_x == RV, "R1 reset reg_q", q_s, RV);
      chk(!upd_s && !upd_x, "R1 reset updated", RW'(upd_s | upd_x), '0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] lf;
      @(negedge clk);
      do_reset();
      // R1: staging reset too - commit untouched buffer in both modes
      op(1, 1, 2'(NS-1), 16'hFFFF, '0, 1, "R1 staging reset");
      // R8: field straddling sub-words 0/1 written piecewise, no commit
      op(1, 1, 2'd0, 16'hBEEF, 2'b11, 0, "R8 partial low");
      op(1, 1, 2'd1, 16'hCAFE, 2'b11, 0, "R8 partial mid");
      op(1, 1, 2'(NS-1), 16'h0F0F, 2'b11, 1, "R4 R6 commit with merge");
      // R2 R3 R5 R6: sweep index x strobe x trigger x hit/en
      for (int k = 0; k < 4 * 4 * 2 * 4; k++) begin
         logic [IW-1:0] ix;
         logic [NB-1:0] sb;
         logic tg, hh, ee;
         ix = 2'(k % 4);
         sb = NB'((k / 4) % 4);
         tg = 1'((k / 16) % 2);
         hh = (k / 32) != 1;
         ee = (k / 32) != 2;
         op(hh, ee, ix, 16'(k * 16'h2B35 + 16'h1357), sb, tg,
            (ix == 2'd3 || !hh || !ee) ? "R3 rejected write" :
            (tg ? "R6 write with trigger" : "R2 R5 strobed write"));
      end
      // pseudo-random phase with a mid-run reset
      lf = 32'hACE1_1234;
      for (int k = 0; k < 400; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         if (k == 200) begin
            op(1, 1, 2'd0, 16'h5A5A, 2'b11, 0, "R2 stage before reset");
            do_reset();
            op(0, 0, 2'd0, 16'h0, '0, 1, "R1 ext commit after reset");
            op(1, 1, 2'(NS-1), 16'h0, '0, 0, "R1 R4 self commit after reset");
         end
         op(lf[3] | lf[4], lf[5] | lf[6], lf[8:7], lf[31:16], lf[10:9], lf[11] & lf[12], "R2 R4 R5 random");
      end
      finish_run();
   end
endmodule